// File: doc/BRIEF.md
# Strided Gather/Scatter Column-Translating Memory Rank

This block models a rank of eight memory chips that all listen to one shared command bus carrying a command, a column address and a pattern identifier. Each chip is fixed to a chip index. Each chip forms its own effective column by XOR-ing the broadcast column with the bitwise AND of the pattern and its chip index. Because of this, a single command can touch a different column in every chip. The pattern is not used for commands other than read and write.

Data is laid out with a column-keyed shuffle: element `i` of column `c` is kept in chip `i XOR c[2:0]`. With that layout, pattern 0 returns one whole column. Patterns 1, 3 and 7 return the eight elements of a stride-2, stride-4 or stride-8 sequence in one access. A write with a non-zero pattern scatters its eight lanes to the same locations that a read with that pattern would gather from. Read data is registered and comes out one cycle after the read command, with the lane of chip `k` at bits `[8k+7:8k]`.

Top module: `gsr_rank`

## Requirements
- R1: After reset, `rvalid_o` is 0, `rdata_o` is 0 and every stored element in every chip is 0.
- R2: For READ (cmd code 1) and WRITE (cmd code 2), chip `k` uses effective column `col_i ^ (k & pat_i)`. With pattern 0, every chip uses `col_i` unchanged.
- R3: One cycle after a READ, `rvalid_o` is 1 and lane `k` of `rdata_o` (bits `[8k+7:8k]`) holds chip `k`'s element at its effective column.
- R4: A WRITE stores lane `k` of `wdata_i` into chip `k` at its effective column and leaves every other location unchanged, for any pattern.
- R5: With the shuffled layout (element `c*8+i` in column `c`, chip `i^c`), a pattern-0 read of column `c` returns exactly the set `{8c .. 8c+7}`.
- R6: With the same layout, patterns 1, 3 and 7 at column `a` return exactly the eight values `base + j*s`, for `j` from 0 to 7. Here `s = pattern+1` and `base = (a & ~pattern)*8 + (a & pattern)`.
- R7: In a cycle after any command other than READ, `rvalid_o` is 0 and `rdata_o` keeps its previous value.
- R8: IDLE (code 0) and OTHER (code 3) never modify storage, whatever the column, pattern and write data.
- R9: Patterns other than 0, 1, 3 and 7 (for example 5) are translated by the same per-chip formula as in R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_i | input | 2 | Command: 0 idle, 1 read, 2 write, 3 other |
| col_i | input | 3 | Broadcast column address |
| pat_i | input | 3 | Broadcast pattern identifier |
| wdata_i | input | 64 | Write data, lane k for chip k |
| rdata_o | output | 64 | Read data, lane k from chip k |
| rvalid_o | output | 1 | Read data valid, one cycle after a read |

## Verification
Each chip keeps its state in its own storage and read lane, so a wrong effective column in one chip shows up in the very next read as a single misplaced lane. The set comparison against the expected stride catches that lane even when the other seven lanes are correct. A write that lands in the wrong column remains hidden until that location is read. For this reason, every scatter is followed by a pattern-0 sweep over all columns, which exposes the bad location within eight reads. Stale or spurious read-valid state shows up one cycle after any non-read command.

// File: rtl/gsr_pkg.sv
package gsr_pkg;
    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_WRITE = 2'd2,
        CMD_OTHER = 2'd3
    } cmd_e;
endpackage

// File: rtl/gsr_col_xlate.sv
module gsr_col_xlate
    import gsr_pkg::*;
#(
    parameter int COL_W   = 3,
    parameter int PAT_W   = 3,
    parameter int CHIP_ID = 0
) (
    input  cmd_e             cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [PAT_W-1:0] pat_i,
    output logic [COL_W-1:0] col_o
);
    localparam logic [PAT_W-1:0] ID = PAT_W'(CHIP_ID);

    logic             is_rw;
    logic [COL_W-1:0] flip;

    always_comb begin
        is_rw = (cmd_i == CMD_READ) || (cmd_i == CMD_WRITE);
        flip  = is_rw ? COL_W'(pat_i & ID) : '0;
        col_o = col_i ^ flip;
    end
endmodule

// File: rtl/gsr_chip.sv
module gsr_chip
    import gsr_pkg::*;
#(
    parameter int DW      = 8,
    parameter int COL_W   = 3,
    parameter int PAT_W   = 3,
    parameter int CHIP_ID = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_e             cmd_i,
    input  logic [COL_W-1:0] col_i,
    input  logic [PAT_W-1:0] pat_i,
    input  logic [DW-1:0]    wlane_i,
    output logic [DW-1:0]    rlane_o
);
    localparam int NCOL = 1 << COL_W;

    typedef struct packed {
        logic [NCOL-1:0][DW-1:0] mem;
        logic [DW-1:0]           rlane;
    } chip_st_t;

    chip_st_t         st_d, st_q;
    logic [COL_W-1:0] col_eff;

    gsr_col_xlate #(
        .COL_W  (COL_W),
        .PAT_W  (PAT_W),
        .CHIP_ID(CHIP_ID)
    ) u_xlate (
        .cmd_i(cmd_i),
        .col_i(col_i),
        .pat_i(pat_i),
        .col_o(col_eff)
    );

    always_comb begin
        st_d = st_q;
        if (cmd_i == CMD_WRITE) begin
            st_d.mem[col_eff] = wlane_i;
        end
        if (cmd_i == CMD_READ) begin
            st_d.rlane = st_q.mem[col_eff];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rlane_o = st_q.rlane;

    // R2: pattern 0 leaves the broadcast column untouched
    assert_pat0_passthru_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ((cmd_i == CMD_READ || cmd_i == CMD_WRITE) && pat_i == '0) |-> (col_eff == col_i));

    // R4: the written lane appears at the translated column
    assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_WRITE) |=> (st_q.mem[$past(col_eff)] == $past(wlane_i)));

    // R8: storage is stable unless written
    assert_nowrite_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i != CMD_WRITE) |=> $stable(st_q.mem));

    // R3: the lane returns the element seen at the translated column
    assert_read_lane_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_i == CMD_READ) |=> (rlane_o == $past(st_q.mem[col_eff])));
endmodule

// File: rtl/gsr_rank.sv
module gsr_rank
    import gsr_pkg::*;
#(
    parameter int NCHIP = 8,
    parameter int DW    = 8,
    parameter int COL_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [1:0]               cmd_i,
    input  logic [COL_W-1:0]         col_i,
    input  logic [$clog2(NCHIP)-1:0] pat_i,
    input  logic [NCHIP*DW-1:0]      wdata_i,
    output logic [NCHIP*DW-1:0]      rdata_o,
    output logic                     rvalid_o
);
    localparam int PAT_W = $clog2(NCHIP);

    typedef struct packed {
        logic rvalid;
    } rank_st_t;

    rank_st_t st_d, st_q;
    cmd_e     cmd;

    assign cmd = cmd_e'(cmd_i);

    for (genvar k = 0; k < NCHIP; k++) begin : g_chip
        gsr_chip #(
            .DW     (DW),
            .COL_W  (COL_W),
            .PAT_W  (PAT_W),
            .CHIP_ID(k)
        ) u_chip (
            .clk    (clk),
            .rst_n  (rst_n),
            .cmd_i  (cmd),
            .col_i  (col_i),
            .pat_i  (pat_i),
            .wlane_i(wdata_i[k*DW +: DW]),
            .rlane_o(rdata_o[k*DW +: DW])
        );
    end

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = (cmd == CMD_READ);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rvalid_o = st_q.rvalid;

    // R3: valid one cycle after a read
    assert_rvalid_after_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_READ) |=> rvalid_o);

    // R7: no valid and held data after non-read commands
    assert_hold_after_nonread_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd != CMD_READ) |=> (!rvalid_o && $stable(rdata_o)));
endmodule

// File: tb/gsr_rank_test.sv
module gsr_rank_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd_i = 2'd0;
    logic [2:0]  col_i = 3'd0;
    logic [2:0]  pat_i = 3'd0;
    logic [63:0] wdata_i = '0;
    logic [63:0] rdata_o;
    logic        rvalid_o;

    int checks = 0;
    int fails = 0;
    logic [7:0] model [8][8];
    logic [63:0] got_data;
    logic        got_valid;

    always #4 clk = ~clk;

    gsr_rank uut (
        .clk(clk), .rst_n(rst_n), .cmd_i(cmd_i), .col_i(col_i),
        .pat_i(pat_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .rvalid_o(rvalid_o)
    );

    // pattern, column, expected base, expected stride
    localparam logic [21:0] VECS [0:11] = '{
        {3'd0, 3'd0, 8'd0,  8'd1},
        {3'd1, 3'd0, 8'd0,  8'd2},
        {3'd3, 3'd0, 8'd0,  8'd4},
        {3'd7, 3'd0, 8'd0,  8'd8},
        {3'd1, 3'd1, 8'd1,  8'd2},
        {3'd3, 3'd1, 8'd1,  8'd4},
        {3'd1, 3'd2, 8'd16, 8'd2},
        {3'd0, 3'd5, 8'd40, 8'd1},
        {3'd7, 3'd3, 8'd3,  8'd8},
        {3'd3, 3'd4, 8'd32, 8'd4},
        {3'd1, 3'd7, 8'd49, 8'd2},
        {3'd3, 3'd6, 8'd34, 8'd4}
    };

    task automatic check(input bit ok, input string req, input logic [63:0] act,
                         input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic [1:0] c, input logic [2:0] col,
                         input logic [2:0] p, input logic [63:0] wd);
        @(negedge clk);
        cmd_i = c; col_i = col; pat_i = p; wdata_i = wd;
        @(negedge clk);
        got_data = rdata_o;
        got_valid = rvalid_o;
        cmd_i = 2'd0;
        if (c == 2'd2) begin
            for (int k = 0; k < 8; k++) model[col ^ (3'(k) & p)][k] = wd[k*8 +: 8];
        end
    endtask

    function automatic logic [63:0] expect_lanes(input logic [2:0] col, input logic [2:0] p);
        logic [63:0] e;
        for (int k = 0; k < 8; k++) e[k*8 +: 8] = model[col ^ (3'(k) & p)][k];
        return e;
    endfunction

    function automatic bit set_ok(input logic [63:0] d, input int base, input int stride);
        for (int j = 0; j < 8; j++) begin
            bit hit;
            hit = 1'b0;
            for (int k = 0; k < 8; k++) if (d[k*8 +: 8] == 8'(base + j*stride)) hit = 1'b1;
            if (!hit) return 1'b0;
        end
        return 1'b1;
    endfunction

    task automatic read_and_check(input logic [2:0] col, input logic [2:0] p, input string req);
        logic [63:0] e;
        e = expect_lanes(col, p);
        do_op(2'd1, col, p, 64'h0);
        check(got_valid == 1'b1, "R3 rvalid", {63'd0, got_valid}, 64'd1);
        check(got_data == e, req, got_data, e);
    endtask

    bit done = 1'b0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] held;
        logic [63:0] wd;
        for (int c = 0; c < 8; c++) for (int k = 0; k < 8; k++) model[c][k] = 8'd0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(rvalid_o == 1'b0, "R1 rvalid reset", {63'd0, rvalid_o}, 64'd0);
        check(rdata_o == 64'd0, "R1 rdata reset", rdata_o, 64'd0);
        rst_n = 1'b1;
        for (int c = 0; c < 8; c++) read_and_check(3'(c), 3'd0, "R1 storage zero");

        // preload shuffled layout: element c*8+i at column c, chip i^c
        for (int c = 0; c < 8; c++) begin
            for (int k = 0; k < 8; k++) wd[k*8 +: 8] = 8'(c*8 + (k ^ c));
            do_op(2'd2, 3'(c), 3'd0, wd);
        end

        // R2 R5 R6: table of pattern reads
        for (int v = 0; v < 12; v++) begin
            logic [2:0] p, a;
            int base, stride;
            p = VECS[v][21:19];
            a = VECS[v][18:16];
            base = int'(VECS[v][15:8]);
            stride = int'(VECS[v][7:0]);
            read_and_check(a, p, "R2 lane placement");
            check(set_ok(got_data, base, stride), (p == 0) ? "R5 stride set" : "R6 stride set",
                  got_data, 64'(base * 256 + stride));
        end

        // R7: hold after idle and after a write
        held = got_data;
        do_op(2'd0, 3'd2, 3'd5, 64'hFFFF_FFFF_FFFF_FFFF);
        check(got_valid == 1'b0, "R7 rvalid low", {63'd0, got_valid}, 64'd0);
        check(got_data == held, "R7 rdata held", got_data, held);
        do_op(2'd2, 3'd0, 3'd0, expect_lanes(3'd0, 3'd0));
        check(got_valid == 1'b0 && got_data == held, "R7 hold after write", got_data, held);

        // R8: idle and other do not touch storage
        do_op(2'd3, 3'd1, 3'd7, 64'hA5A5_A5A5_A5A5_A5A5);
        do_op(2'd0, 3'd4, 3'd3, 64'h5A5A_5A5A_5A5A_5A5A);
        for (int c = 0; c < 8; c++) read_and_check(3'(c), 3'd0, "R8 storage unchanged");

        // R4: scatter with pattern 3 then sweep every column
        do_op(2'd2, 3'd1, 3'd3, 64'hF7F6_F5F4_F3F2_F1F0);
        for (int c = 0; c < 8; c++) read_and_check(3'(c), 3'd0, "R4 scatter sweep");
        read_and_check(3'd1, 3'd3, "R4 gather matches scatter");
        check(got_data == 64'hF7F6_F5F4_F3F2_F1F0, "R4 round trip", got_data,
              64'hF7F6_F5F4_F3F2_F1F0);

        // R9: irregular patterns follow the same formula
        read_and_check(3'd2, 3'd5, "R9 pattern 5");
        read_and_check(3'd6, 3'd6, "R9 pattern 6");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule